// File: doc/BRIEF.md
# I2S to Simultaneous Offset-Binary Converter

This block takes a stereo I2S stream at 64 bit clocks per sample frame and re-formats it for a multibit audio DAC that expects both channels at once. It has no master clock: every register runs from the incoming bit clock. A frame position counter is forced to a known value on each word-select edge. The first 16 bits of each 32-bit slot are captured, and each sample is turned from two's complement into offset binary by inverting its top bit.

During the frame after capture, the left and right words leave the block together, MSB first, on two data lines. Both lines share one output bit clock, which is a gated copy of the input bit clock carrying exactly 16 pulses per frame. A latch-enable strobe then tells the DAC to take the new words. The strobe rises at a fixed frame position. It falls at a position set on an input port, so its length can be tuned without changing the design.

Top module: `i2s_sim_conv`

## Requirements
- R1: The serial input is sampled on the rising bit-clock edge. Frame position 0 is the first rising edge at which word-select is seen low after being high, and position 32 is the first rising edge at which it is seen high after being low. Sample bit k (k = 0 is the MSB) of the left slot is taken at position 1+k and of the right slot at position 33+k, for k = 0..15. Slot bits after the sixteenth have no effect on the output words.
- R2: Each output word is the captured two's-complement sample with its most significant bit inverted (input 0x0000 gives 0x8000, 0x8000 gives 0x0000, 0x7FFF gives 0xFFFF, 0xFFFF gives 0x7FFF).
- R3: The left word appears on `dac_dl_o` and the right word on `dac_dr_o`, MSB first, both sampled by the DAC on the rising edges of the single output clock `dac_bck_o`. The data lines change only while the bit clock is low.
- R4: `dac_bck_o` follows the bit clock at frame positions 1 through 16 only, giving exactly 16 rising edges per frame, and is held low at all other times.
- R5: Samples captured in one frame are shifted out during the next frame (one frame of latency), and both words are loaded together.
- R6: `dac_le_o` rises in the low half of the bit-clock period that follows frame position 17, provided word-select is low.
- R7: `dac_le_o` falls in the low half of the period that follows the position equal to `le_end_i`, so it stays high for `le_end_i` - 17 bit-clock periods (21 gives 4, 28 gives 11).
- R8: Any word-select edge forces the frame position, so the capture and output alignment recover in the frame after a slot of the wrong length (slots shorter than 18 bits are not supported).
- R9: During reset and until the second word-select falling edge after reset, `dac_bck_o`, `dac_le_o`, `dac_dl_o` and `dac_dr_o` stay low.
- R10: Outside the 16 data bits of a frame, both data lines are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk_i | input | 1 | Incoming bit clock, 64 cycles per frame; clocks all logic |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ws_i | input | 1 | Word-select: low for the left slot, high for the right slot |
| sd_i | input | 1 | Serial data, two's complement, MSB first |
| le_end_i | input | 6 | Frame position at which the latch-enable strobe ends |
| dac_bck_o | output | 1 | Gated bit clock shared by both data lines |
| dac_dl_o | output | 1 | Left-channel offset-binary serial data |
| dac_dr_o | output | 1 | Right-channel offset-binary serial data |
| dac_le_o | output | 1 | Latch-enable strobe to the DAC |

## Verification
The checker watches the framing on every cycle. It confirms that the gated clock is only present at frame positions 1 to 16 while word-select is low. It confirms that the strobe rises exactly after position 17 and only falls once the position has reached the programmed end. It also confirms that nothing leaves the block before it is armed. Several things can only be shown by the bench scenarios, by decoding the DAC side with the gated clock: the numeric result of the offset-binary conversion, the one-frame latency, the insensitivity to the lower half of each slot, the strobe length for two different end values, and recovery after slots of the wrong length.

// File: rtl/i2s_sim_pkg.sv
package i2s_sim_pkg;
    // Default geometry of the incoming stream and of the DAC words.
    localparam int unsigned DEF_SLOT_W   = 32;
    localparam int unsigned DEF_SAMPLE_W = 16;
    // Left and right lanes.
    localparam int unsigned NUM_LANES    = 2;
endpackage

// File: rtl/i2s_frame_tracker.sv
// Frame position counter resynchronised on word-select edges, plus arming.
module i2s_frame_tracker #(
    parameter int unsigned SLOT_W = 32,
    parameter int unsigned CNT_W  = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ws_i,
    output logic [CNT_W-1:0] pos_d_o,
    output logic [CNT_W-1:0] pos_q_o,
    output logic             ws_q_o,
    output logic             armed_o
);
    localparam logic [CNT_W-1:0] POS_HALF = CNT_W'(SLOT_W);
    localparam logic [CNT_W-1:0] POS_MAX  = CNT_W'(2 * SLOT_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0] pos;
        logic             ws;
        logic             fall_seen;
        logic             armed;
    } trk_t;

    trk_t trk_d, trk_q;
    logic ws_fall, ws_rise;

    always_comb begin
        trk_d   = trk_q;
        ws_fall = trk_q.ws & ~ws_i;
        ws_rise = ~trk_q.ws & ws_i;
        trk_d.ws = ws_i;
        if (ws_fall) begin
            trk_d.pos = '0;
        end else if (ws_rise) begin
            trk_d.pos = POS_HALF;
        end else if (trk_q.pos != POS_MAX) begin
            trk_d.pos = trk_q.pos + 1'b1;
        end
        if (ws_fall) begin
            trk_d.fall_seen = 1'b1;
            if (trk_q.fall_seen) begin
                trk_d.armed = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            trk_q <= '{pos: POS_MAX, ws: 1'b0, fall_seen: 1'b0, armed: 1'b0};
        end else begin
            trk_q <= trk_d;
        end
    end

    assign pos_d_o = trk_d.pos;
    assign pos_q_o = trk_q.pos;
    assign ws_q_o  = trk_q.ws;
    assign armed_o = trk_q.armed;
endmodule

// File: rtl/i2s_slot_capture.sv
// Captures the leading bits of one slot and holds the finished word.
module i2s_slot_capture #(
    parameter int unsigned SAMPLE_W = 16,
    parameter int unsigned CNT_W    = 6,
    parameter int unsigned FIRST    = 1,
    parameter int unsigned XFER     = 49
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                sd_i,
    input  logic [CNT_W-1:0]    pos_i,
    output logic [SAMPLE_W-1:0] hold_o
);
    localparam logic [CNT_W-1:0] POS_LO = CNT_W'(FIRST);
    localparam logic [CNT_W-1:0] POS_HI = CNT_W'(FIRST + SAMPLE_W - 1);
    localparam logic [CNT_W-1:0] POS_XF = CNT_W'(XFER);

    typedef struct packed {
        logic [SAMPLE_W-1:0] shift;
        logic [SAMPLE_W-1:0] hold;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (pos_i >= POS_LO && pos_i <= POS_HI) begin
            cap_d.shift = {cap_q.shift[SAMPLE_W-2:0], sd_i};
        end
        if (pos_i == POS_XF) begin
            cap_d.hold = cap_q.shift;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign hold_o = cap_q.hold;
endmodule

// File: rtl/i2s_lane_shifter.sv
// Falling-edge output shift register for one DAC lane, with MSB inversion.
module i2s_lane_shifter #(
    parameter int unsigned SAMPLE_W = 16
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                load_i,
    input  logic                shift_i,
    input  logic [SAMPLE_W-1:0] word_i,
    output logic                bit_o
);
    typedef struct packed {
        logic [SAMPLE_W-1:0] sh;
    } lane_t;

    lane_t lane_d, lane_q;

    always_comb begin
        lane_d = lane_q;
        if (load_i) begin
            lane_d.sh = {~word_i[SAMPLE_W-1], word_i[SAMPLE_W-2:0]};
        end else if (shift_i) begin
            lane_d.sh = {lane_q.sh[SAMPLE_W-2:0], 1'b0};
        end
    end

    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lane_q <= '0;
        end else begin
            lane_q <= lane_d;
        end
    end

    assign bit_o = lane_q.sh[SAMPLE_W-1];
endmodule

// File: rtl/i2s_strobe_gen.sv
// Falling-edge clock gate enable and latch-enable strobe.
module i2s_strobe_gen #(
    parameter int unsigned SAMPLE_W = 16,
    parameter int unsigned CNT_W    = 6,
    parameter int unsigned LE_START = 17
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] pos_i,
    input  logic             ws_i,
    input  logic             armed_i,
    input  logic [CNT_W-1:0] le_end_i,
    output logic             gate_o,
    output logic             le_o,
    output logic             load_o,
    output logic             shift_o
);
    localparam logic [CNT_W-1:0] POS_BITS = CNT_W'(SAMPLE_W);
    localparam logic [CNT_W-1:0] POS_LE   = CNT_W'(LE_START);

    typedef struct packed {
        logic gate;
        logic le;
    } stb_t;

    stb_t stb_d, stb_q;

    always_comb begin
        stb_d      = stb_q;
        load_o     = armed_i & ~ws_i & (pos_i == '0);
        shift_o    = armed_i & (pos_i != '0) & (pos_i <= POS_BITS);
        stb_d.gate = armed_i & ~ws_i & (pos_i < POS_BITS);
        if (!armed_i) begin
            stb_d.le = 1'b0;
        end else if (pos_i == POS_LE && !ws_i) begin
            stb_d.le = 1'b1;
        end else if (pos_i >= le_end_i) begin
            stb_d.le = 1'b0;
        end
    end

    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stb_q <= '0;
        end else begin
            stb_q <= stb_d;
        end
    end

    assign gate_o = stb_q.gate;
    assign le_o   = stb_q.le;
endmodule

// File: rtl/i2s_sim_conv.sv
// I2S (64 bit clocks per frame) to two-lane simultaneous offset-binary output.
module i2s_sim_conv #(
    parameter int unsigned SLOT_W   = i2s_sim_pkg::DEF_SLOT_W,
    parameter int unsigned SAMPLE_W = i2s_sim_pkg::DEF_SAMPLE_W
) (
    input  logic                          bclk_i,
    input  logic                          rst_ni,
    input  logic                          ws_i,
    input  logic                          sd_i,
    input  logic [$clog2(2*SLOT_W)-1:0]   le_end_i,
    output logic                          dac_bck_o,
    output logic                          dac_dl_o,
    output logic                          dac_dr_o,
    output logic                          dac_le_o
);
    localparam int unsigned CNT_W    = $clog2(2 * SLOT_W);
    localparam int unsigned LANES    = i2s_sim_pkg::NUM_LANES;
    localparam int unsigned LE_START = SAMPLE_W + 1;
    localparam int unsigned XFER     = SLOT_W + SAMPLE_W + 1;

    logic [CNT_W-1:0]    pos_d, pos_q;
    logic                ws_s, armed;
    logic                gate_en, le_q, load_en, shift_en;
    logic [SAMPLE_W-1:0] hold_w [LANES];
    logic                lane_bit [LANES];

    i2s_frame_tracker #(.SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_trk (
        .clk_i   (bclk_i),
        .rst_ni  (rst_ni),
        .ws_i    (ws_i),
        .pos_d_o (pos_d),
        .pos_q_o (pos_q),
        .ws_q_o  (ws_s),
        .armed_o (armed)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        i2s_slot_capture #(
            .SAMPLE_W (SAMPLE_W),
            .CNT_W    (CNT_W),
            .FIRST    (1 + g * SLOT_W),
            .XFER     (XFER)
        ) u_cap (
            .clk_i  (bclk_i),
            .rst_ni (rst_ni),
            .sd_i   (sd_i),
            .pos_i  (pos_d),
            .hold_o (hold_w[g])
        );

        i2s_lane_shifter #(.SAMPLE_W(SAMPLE_W)) u_shf (
            .clk_i   (bclk_i),
            .rst_ni  (rst_ni),
            .load_i  (load_en),
            .shift_i (shift_en),
            .word_i  (hold_w[g]),
            .bit_o   (lane_bit[g])
        );
    end

    i2s_strobe_gen #(
        .SAMPLE_W (SAMPLE_W),
        .CNT_W    (CNT_W),
        .LE_START (LE_START)
    ) u_stb (
        .clk_i    (bclk_i),
        .rst_ni   (rst_ni),
        .pos_i    (pos_q),
        .ws_i     (ws_s),
        .armed_i  (armed),
        .le_end_i (le_end_i),
        .gate_o   (gate_en),
        .le_o     (le_q),
        .load_o   (load_en),
        .shift_o  (shift_en)
    );

    // gate_en changes only while bclk_i is low, so the gated clock has no runt pulses.
    assign dac_bck_o = bclk_i & gate_en;
    assign dac_dl_o  = lane_bit[0];
    assign dac_dr_o  = lane_bit[1];
    assign dac_le_o  = le_q;
endmodule

// File: rtl/i2s_sim_conv_chk.sv
// Property checker for i2s_sim_conv, attached with bind.
module i2s_sim_conv_chk #(
    parameter int unsigned CNT_W    = 6,
    parameter int unsigned SAMPLE_W = 16,
    parameter int unsigned LE_START = 17
) (
    input logic             bclk_i,
    input logic             rst_ni,
    input logic             ws_s,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] le_end,
    input logic             armed,
    input logic             gate,
    input logic             le,
    input logic             dl,
    input logic             dr
);
    // R6: strobe rises only right after position 17 with word-select low
    assert_le_start_R6: assert property (@(posedge bclk_i) disable iff (!rst_ni)
        $rose(le) |-> (cnt == CNT_W'(LE_START) && !ws_s));

    // R7: strobe falls only once the programmed end position is reached
    assert_le_stop_R7: assert property (@(posedge bclk_i) disable iff (!rst_ni)
        $fell(le) |-> (cnt >= le_end || !armed));

    // R4: gated clock pulses only at positions 1..16 inside the left slot
    assert_gate_window_R4: assert property (@(posedge bclk_i) disable iff (!rst_ni)
        gate |-> (cnt < CNT_W'(SAMPLE_W) && !ws_s));

    // R4: the pulse train starts at position 1
    assert_gate_first_R4: assert property (@(posedge bclk_i) disable iff (!rst_ni)
        $rose(gate) |-> (cnt == '0));

    // R9: nothing leaves the block before arming
    assert_quiet_R9: assert property (@(posedge bclk_i) disable iff (!rst_ni)
        !armed |-> (!gate && !le && !dl && !dr));
endmodule

bind i2s_sim_conv i2s_sim_conv_chk #(
    .CNT_W    (CNT_W),
    .SAMPLE_W (SAMPLE_W),
    .LE_START (LE_START)
) u_chk (
    .bclk_i (bclk_i),
    .rst_ni (rst_ni),
    .ws_s   (ws_s),
    .cnt    (pos_q),
    .le_end (le_end_i),
    .armed  (armed),
    .gate   (gate_en),
    .le     (dac_le_o),
    .dl     (dac_dl_o),
    .dr     (dac_dr_o)
);

// File: tb/sim_i2s_sim_conv.sv
module sim_i2s_sim_conv;
    localparam int CLK_PERIOD = 10;

    logic       bclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ws = 1'b1;
    logic       sd = 1'b0;
    logic [5:0] le_end = 6'd21;
    logic       dac_bck, dac_dl, dac_dr, dac_le;

    int nchk = 0;
    int nerr = 0;
    int bpos = 0;
    logic ws_p = 1'b0;
    int le_w = 0;
    int pulses = 0;
    int first_pos = 0;
    int exp_lew = 4;
    logic [15:0] rx_l = '0, rx_r = '0;
    logic [15:0] expq_l[$];
    logic [15:0] expq_r[$];

    i2s_sim_conv u0 (
        .bclk_i   (bclk),
        .rst_ni   (rst_n),
        .ws_i     (ws),
        .sd_i     (sd),
        .le_end_i (le_end),
        .dac_bck_o(dac_bck),
        .dac_dl_o (dac_dl),
        .dac_dr_o (dac_dr),
        .dac_le_o (dac_le)
    );

    always #(CLK_PERIOD/2) bclk = ~bclk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Frame position as defined in R1, strobe width in bit clocks (R7).
    always @(posedge bclk) begin
        ws_p <= ws;
        if (!ws && ws_p) bpos <= 0;
        else bpos <= bpos + 1;
        if (dac_le) le_w <= le_w + 1;
        else le_w <= 0;
    end

    // DAC-side receiver: gated clock edges and strobe rise.
    always @(posedge dac_bck or posedge dac_le) begin
        if (dac_bck) begin
            rx_l = {rx_l[14:0], dac_dl};
            rx_r = {rx_r[14:0], dac_dr};
            if (pulses == 0) first_pos = bpos + 1;
            pulses++;
        end else begin
            chk(bpos == 17, "R6", "strobe rise position", bpos, 17);
            chk(!dac_dl && !dac_dr, "R10", "data lines idle at strobe", {dac_dl, dac_dr}, 0);
            if (expq_l.size() == 0) begin
                chk(1'b0, "R9", "strobe before first full period", 1, 0);
            end else begin
                logic [15:0] el, er;
                el = expq_l.pop_front();
                er = expq_r.pop_front();
                chk(rx_l == el, "R2", "left word", rx_l, el);
                chk(rx_r == er, "R3", "right word", rx_r, er);
                chk(pulses == 16, "R4", "gated pulses per frame", pulses, 16);
                chk(first_pos == 1, "R4", "first pulse position", first_pos, 1);
            end
            pulses = 0;
        end
    end

    always @(negedge dac_le) begin
        if (rst_n) chk(le_w == exp_lew, "R7", "strobe width", le_w, exp_lew);
    end

    // One I2S slot: word-select changes with the first bit clock, MSB one clock later.
    task automatic send_slot(input logic w, input logic [31:0] word, input int len);
        for (int i = 0; i < len; i++) begin
            @(negedge bclk);
            ws = w;
            if (i > 0) begin
                int k;
                k = 32 - i;
                sd = (k >= 0) ? word[k] : 1'b0;
            end
        end
    endtask

    task automatic send_frame(input logic [15:0] l, input logic [15:0] r,
                              input logic [15:0] jl, input logic [15:0] jr,
                              input int ll, input int lr);
        send_slot(1'b0, {l, jl}, ll);
        send_slot(1'b1, {r, jr}, lr);
        expq_l.push_back(l ^ 16'h8000);   // R2/R5: shown during the next frame
        expq_r.push_back(r ^ 16'h8000);
    endtask

    task automatic t_reset();
        repeat (4) @(negedge bclk);
        chk({dac_bck, dac_le, dac_dl, dac_dr} == 4'b0, "R9", "outputs in reset",
            {dac_bck, dac_le, dac_dl, dac_dr}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge bclk);
    endtask

    task automatic t_first_period();
        send_frame(16'h1357, 16'h2468, 16'h0000, 16'h0000, 32, 32);
        chk(pulses == 0, "R9", "no gated pulses before arming", pulses, 0);
        chk(!dac_le && !dac_dl && !dac_dr, "R9", "quiet before arming",
            {dac_le, dac_dl, dac_dr}, 0);
    endtask

    task automatic t_patterns();
        // R2 R5: boundary codes and mixed patterns, each checked one frame later
        send_frame(16'h0000, 16'h7FFF, 16'h0000, 16'h0000, 32, 32);
        send_frame(16'h8000, 16'hFFFF, 16'h0000, 16'h0000, 32, 32);
        send_frame(16'h1234, 16'hEDCB, 16'h0000, 16'h0000, 32, 32);
        send_frame(16'hA5A5, 16'h5A5A, 16'h0000, 16'h0000, 32, 32);
    endtask

    task automatic t_junk();
        // R1: trailing slot bits set must not reach the words
        send_frame(16'h0F0F, 16'hF0F0, 16'hFFFF, 16'hAAAA, 32, 32);
        send_frame(16'h0001, 16'hFFFE, 16'h5555, 16'hFFFF, 32, 32);
    endtask

    task automatic t_le_len();
        // R7: longer strobe, then back to the short one
        le_end  = 6'd28;
        exp_lew = 11;
        send_frame(16'h4000, 16'hC000, 16'h0000, 16'h0000, 32, 32);
        send_frame(16'h7F00, 16'h00FF, 16'h0000, 16'h0000, 32, 32);
        le_end  = 6'd21;
        exp_lew = 4;
        send_frame(16'h3C3C, 16'hC3C3, 16'h0000, 16'h0000, 32, 32);
    endtask

    task automatic t_slip();
        // R8: wrong slot lengths, alignment must follow the word-select edges
        send_frame(16'h6789, 16'h9876, 16'hFFFF, 16'hFFFF, 24, 40);
        send_frame(16'hBEEF, 16'h0BAD, 16'h0000, 16'h0000, 32, 32);
        send_frame(16'h2222, 16'hDDDD, 16'h0000, 16'h0000, 40, 20);
        send_frame(16'hCAFE, 16'hF00D, 16'h1111, 16'h0000, 32, 32);
    endtask

    initial begin
        t_reset();
        t_first_period();
        t_patterns();
        t_junk();
        t_le_len();
        t_slip();
        send_frame(16'h0000, 16'h0000, 16'h0000, 16'h0000, 32, 32);
        send_frame(16'h0000, 16'h0000, 16'h0000, 16'h0000, 32, 32);
        chk(expq_l.size() == 1, "R5", "frames left unchecked", expq_l.size(), 1);
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        nerr++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule